// File: doc/BRIEF.md
# Trap-Aware Decoding Iteration Controller

This block sequences the iterations of a belief-propagation decoder core for one received frame. After a start pulse it asks the core to load the frame, then launches one iteration at a time. It counts iterations and, as each one finishes, checks three things. It ends the frame with success when the parity checks are all met, and with failure when the iteration budget is used up. Otherwise it launches the next iteration.

The core also raises a trap flag when its syndrome has stalled at a nonzero value. The controller may then pause the iterations and start a separate neutralization network, but only once per frame and only when enough budget is left. When the network reports done, the controller adds the network's fixed cycle count to the iteration counter, as if those cycles were iterations, and resumes normal iterations. If no trap is taken, the block is a plain bounded iteration loop.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `success_o`, `failure_o`, `frame_start_o`, `iter_start_o` and `nt_start_o` are 0 and `iter_cnt_o` is 0.
- R2: A rising edge on `start_i` while idle starts a frame. It gives one `frame_start_o` pulse, clears the counter and both status levels, and is followed by the first `iter_start_o` pulse.
- R3: A rising edge on `start_i` while busy has no effect: only one `frame_start_o` pulse is issued per frame.
- R4: Every finished iteration (`iter_done_i` while waiting) adds 1 to `iter_cnt_o`, and each `iter_start_o` pulse launches exactly one iteration.
- R5: If `valid_i` is 1 at a finished iteration, the frame ends with `success_o`=1 and one `done_o` pulse. This check takes priority over the limit, so a frame that becomes valid at count `MAX_ITER` succeeds.
- R6: If the count reaches `MAX_ITER` without `valid_i`, the frame ends with `failure_o`=1, one `done_o` pulse and `iter_cnt_o`=`MAX_ITER`. `success_o` and `failure_o` are never both 1.
- R7: A trap at a finished iteration starts neutralization (one `nt_start_o` pulse in place of the next `iter_start_o`) only if no neutralization has yet run in the frame and the updated count plus `NT_CYCLES` is strictly less than `MAX_ITER`.
- R8: From `nt_start_o` until `nt_done_i`, no `iter_start_o` is issued. Iterations resume with an `iter_start_o` pulse afterwards.
- R9: On `nt_done_i`, `iter_cnt_o` rises by `NT_CYCLES`, and later trap flags in the same frame are ignored.
- R10: A trap that is not permitted by R7 is ignored and the next iteration is launched as usual.
- R11: With no trap taken, the frame's final count equals the number of iterations run.
- R12: After a frame ends the block is idle. A `start_i` held high across the end of the frame does not start a new one; a fresh rising edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request; its rising edge is used |
| frame_start_o | output | 1 | One-cycle pulse: core loads the new frame |
| iter_start_o | output | 1 | One-cycle pulse: core runs one iteration |
| iter_done_i | input | 1 | Core finished the launched iteration |
| valid_i | input | 1 | All parity checks met, qualified by `iter_done_i` |
| trap_i | input | 1 | Stalled nonzero syndrome, qualified by `iter_done_i` |
| nt_start_o | output | 1 | One-cycle pulse: start neutralization |
| nt_done_i | input | 1 | Neutralization network finished |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| success_o | output | 1 | Last frame ended valid; held until next frame |
| failure_o | output | 1 | Last frame hit the limit; held until next frame |
| iter_cnt_o | output | $clog2(MAX_ITER+1) | Iterations charged in the current or last frame |

## Verification
The bench builds the block with `MAX_ITER`=16 and `NT_CYCLES`=3, so a frame reaches the limit within a few dozen cycles. With these values the permission boundary is easy to hit. A trap at count 12 is taken (12+3<16), and a trap at count 13 is refused. The same values let a frame succeed at exactly count 16, and let a taken neutralization push the count to 15 just before a limit failure. Random frames mix the valid point, the onset of the trap and the core latency, and each frame's outcome is compared with a bench model of the budget rule.

// File: rtl/ldpc_ictl_pkg.sv
package ldpc_ictl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_LAUNCH,
    ST_WAIT,
    ST_NT_LAUNCH,
    ST_NT_WAIT
  } ictl_state_e;
endpackage

// File: rtl/ldpc_ictl_counter.sv
module ldpc_ictl_counter #(
  parameter int MAX_ITER  = 64,
  parameter int NT_CYCLES = 4,
  localparam int CNT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             charge_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] NtInc = CNT_W'(NT_CYCLES);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_ITER);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + 1'b1;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (charge_i) cnt_q <= cnt_q + NtInc;
    else if (inc_i)    cnt_q <= cnt_next_o;
  end

  // budget is never overrun, neither by iterations nor by a charge
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MaxCnt);
  p_cnt_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/ldpc_ictl_permit.sv
module ldpc_ictl_permit #(
  parameter int MAX_ITER  = 64,
  parameter int NT_CYCLES = 4,
  localparam int CNT_W    = $clog2(MAX_ITER + 1),
  localparam int SUM_W    = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             mark_i,
  input  logic             trap_i,
  input  logic [CNT_W-1:0] cnt_next_i,
  output logic             used_o,
  output logic             permit_o
);
  localparam logic [SUM_W-1:0] NtSum  = SUM_W'(NT_CYCLES);
  localparam logic [SUM_W-1:0] MaxSum = SUM_W'(MAX_ITER);

  logic             used_q;
  logic [SUM_W-1:0] proj_cnt;

  assign proj_cnt = {1'b0, cnt_next_i} + NtSum;
  assign permit_o = trap_i && !used_q && (proj_cnt < MaxSum);
  assign used_o   = used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     used_q <= 1'b0;
    else if (clr_i)  used_q <= 1'b0;
    else if (mark_i) used_q <= 1'b1;
  end

  p_used_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q && !clr_i) |=> used_q);
endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
  import ldpc_ictl_pkg::*;
#(
  parameter int MAX_ITER  = 64,
  parameter int NT_CYCLES = 4,
  localparam int CNT_W    = $clog2(MAX_ITER + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             frame_start_o,
  output logic             iter_start_o,
  input  logic             iter_done_i,
  input  logic             valid_i,
  input  logic             trap_i,
  output logic             nt_start_o,
  input  logic             nt_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             success_o,
  output logic             failure_o,
  output logic [CNT_W-1:0] iter_cnt_o
);
  localparam logic [CNT_W-1:0] MaxCnt = CNT_W'(MAX_ITER);
  localparam logic [CNT_W-1:0] NtInc  = CNT_W'(NT_CYCLES);

  ictl_state_e      state_q, state_d;
  logic             start_q, start_rise;
  logic             accept, finish_iter, finish_nt;
  logic             permit, nt_used;
  logic             ok_d, fail_d;
  logic [CNT_W-1:0] cnt, cnt_next;

  assign start_rise  = start_i && !start_q;
  assign accept      = (state_q == ST_IDLE) && start_rise;
  assign finish_iter = (state_q == ST_WAIT) && iter_done_i;
  assign finish_nt   = (state_q == ST_NT_WAIT) && nt_done_i;

  ldpc_ictl_counter #(.MAX_ITER(MAX_ITER), .NT_CYCLES(NT_CYCLES)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .inc_i      (finish_iter),
    .charge_i   (finish_nt),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  ldpc_ictl_permit #(.MAX_ITER(MAX_ITER), .NT_CYCLES(NT_CYCLES)) u_permit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .mark_i     (finish_nt),
    .trap_i     (trap_i),
    .cnt_next_i (cnt_next),
    .used_o     (nt_used),
    .permit_o   (permit)
  );

  // valid checked before the limit
  always_comb begin
    state_d = state_q;
    ok_d    = 1'b0;
    fail_d  = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start_rise) state_d = ST_FRAME;
      ST_FRAME:     state_d = ST_LAUNCH;
      ST_LAUNCH:    state_d = ST_WAIT;
      ST_WAIT: begin
        if (iter_done_i) begin
          if (valid_i) begin
            ok_d    = 1'b1;
            state_d = ST_IDLE;
          end else if (cnt_next >= MaxCnt) begin
            fail_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (permit) begin
            state_d = ST_NT_LAUNCH;
          end else begin
            state_d = ST_LAUNCH;
          end
        end
      end
      ST_NT_LAUNCH: state_d = ST_NT_WAIT;
      ST_NT_WAIT:   if (nt_done_i) state_d = ST_LAUNCH;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      start_q   <= 1'b0;
      done_o    <= 1'b0;
      success_o <= 1'b0;
      failure_o <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
      done_o  <= ok_d || fail_d;
      if (accept) begin
        success_o <= 1'b0;
        failure_o <= 1'b0;
      end else begin
        if (ok_d)   success_o <= 1'b1;
        if (fail_d) failure_o <= 1'b1;
      end
    end
  end

  assign frame_start_o = (state_q == ST_FRAME);
  assign iter_start_o  = (state_q == ST_LAUNCH);
  assign nt_start_o    = (state_q == ST_NT_LAUNCH);
  assign busy_o        = (state_q != ST_IDLE);
  assign iter_cnt_o    = cnt;

  p_excl_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(success_o && failure_o));
  p_valid_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && iter_done_i && valid_i) |=> (success_o && done_o));
  p_fail_at_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && failure_o) |-> (iter_cnt_o == MaxCnt));
  p_once_per_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nt_used |-> !nt_start_o);
  p_paused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NT_WAIT && !nt_done_i) |=> !iter_start_o);
  p_charge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_nt |=> (iter_cnt_o == $past(iter_cnt_o) + NtInc));
  p_stay_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_rise) |=> !busy_o);
  p_busy_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_IDLE) |-> !frame_start_o || $past(state_q) == ST_IDLE);
endmodule

// File: tb/ldpc_iter_ctrl_bench.sv
module ldpc_iter_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_ITER   = 16;
  localparam int NT_CYCLES  = 3;
  localparam int CNT_W      = $clog2(MAX_ITER + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, iter_done_i = 1'b0, valid_i = 1'b0, trap_i = 1'b0, nt_done_i = 1'b0;
  logic frame_start_o, iter_start_o, nt_start_o, busy_o, done_o, success_o, failure_o;
  logic [CNT_W-1:0] iter_cnt_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldpc_iter_ctrl #(.MAX_ITER(MAX_ITER), .NT_CYCLES(NT_CYCLES)) u_ldpc_iter_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .frame_start_o(frame_start_o), .iter_start_o(iter_start_o),
    .iter_done_i(iter_done_i), .valid_i(valid_i), .trap_i(trap_i),
    .nt_start_o(nt_start_o), .nt_done_i(nt_done_i),
    .busy_o(busy_o), .done_o(done_o), .success_o(success_o),
    .failure_o(failure_o), .iter_cnt_o(iter_cnt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // budget model: returns outcome (1 ok, 0 fail), charged count, iterations run, neutralizations
  task automatic model(input int valid_it, input int trap_from,
                       output int ok, output int cnt, output int iters, output int nts);
    int used = 0;
    cnt = 0; iters = 0; nts = 0; ok = 0;
    forever begin
      iters++; cnt++;
      if (iters == valid_it) begin ok = 1; return; end
      if (cnt >= MAX_ITER) begin ok = 0; return; end
      if (trap_from != 0 && iters >= trap_from && used == 0 && cnt + NT_CYCLES < MAX_ITER) begin
        used = 1; nts++; cnt += NT_CYCLES;
      end
    end
  endtask

  // mode 0 normal, 1 start held high, 2 extra start pulse mid-frame
  task automatic run_frame(input int valid_it, input int trap_from, input int lat, input int mode);
    int e_ok, e_cnt, e_it, e_nt;
    int kk = 0, nts = 0, fstarts = 0, cyc = 0, iw = 0, nw = 0, overlap = 0;
    bit fin = 0;
    model(valid_it, trap_from, e_ok, e_cnt, e_it, e_nt);
    @(negedge clk);
    start_i = 1'b1;
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      iter_done_i = 1'b0; valid_i = 1'b0; trap_i = 1'b0; nt_done_i = 1'b0;
      if (cyc == 1 && mode != 1) start_i = 1'b0;
      if (mode == 2 && cyc == 4) start_i = 1'b1;
      if (mode == 2 && cyc == 5) start_i = 1'b0;
      if (frame_start_o) fstarts++;
      if (done_o) fin = 1;
      else if (iter_start_o) begin
        if (nw > 0) overlap++;
        kk++; iw = lat;
      end else if (nt_start_o) begin
        nts++; nw = lat + 1;
      end else if (iw > 0) begin
        iw--;
        if (iw == 0) begin
          iter_done_i = 1'b1;
          valid_i = (kk == valid_it);
          trap_i  = (trap_from != 0 && kk >= trap_from);
        end
      end else if (nw > 0) begin
        nw--;
        if (nw == 0) nt_done_i = 1'b1;
      end
    end
    chk("R5/R6 frame ended", int'(fin), 1);
    chk("R5 success level", int'(success_o), e_ok);
    chk("R6 failure level", int'(failure_o), 1 - e_ok);
    chk("R4/R9/R11 charged count", int'(iter_cnt_o), e_cnt);
    chk("R4 iterations launched", kk, e_it);
    chk("R7 neutralizations", nts, e_nt);
    chk("R8 no iteration during neutralization", overlap, 0);
    chk("R2/R3 one frame_start per frame", fstarts, 1);
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      chk("R12 held start does not restart", int'(busy_o), 0);
      start_i = 1'b0;
    end
    @(negedge clk);
    chk("R12 idle after frame", int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 success", int'(success_o), 0);
    chk("R1 failure", int'(failure_o), 0);
    chk("R1 count", int'(iter_cnt_o), 0);
    chk("R1 starts", int'(frame_start_o | iter_start_o | nt_start_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 no start no frame", int'(busy_o), 0);

    run_frame(5, 0, 1, 0);    // R5, R11
    run_frame(0, 0, 2, 0);    // R6 limit, R11
    run_frame(16, 0, 1, 0);   // R5 valid at the last count
    run_frame(7, 4, 2, 0);    // R7, R9 second trap ignored
    run_frame(0, 13, 1, 0);   // R10 refused at 13+3=16
    run_frame(0, 12, 1, 0);   // R7 accepted at 12+3=15
    run_frame(13, 12, 3, 0);  // R5 success at count 16 after charge
    run_frame(6, 2, 1, 1);    // R12 held start
    run_frame(0, 3, 2, 2);    // R3 start while busy
    for (int i = 0; i < 40; i++)
      run_frame(int'($urandom % 20), int'($urandom % 18), 1 + int'($urandom % 3), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule